// File: doc/BRIEF.md
# Transmit Alignment FIFO

This block carries a stream of 16-bit transmit words from the clock that the word source returns into an internal read clock. Both clocks run at the same nominal frequency but have no fixed phase relation. The store is a small circular buffer. The write and read positions cross between the two domains as Gray-coded pointers through flop synchronizers. The read domain keeps watching how far apart the two positions are.

When the separation gets too small in either direction, a sticky error state is set. This state is returned to the source as `phase_err`. While it is set, the read side sends a fixed idle word. The source answers with an init request, which is `init_in` held high for two consecutive write cycles. The read domain then re-centres its pointer half the buffer away from the write pointer and clears the error. The flag falls at the source a few cycles later, and the source resumes real data.

Writes happen on every write cycle and reads on every read cycle. The block never applies back-pressure. Words that arrive while the flag is high are treated as filler and are overwritten.

Top module: `txalign_fifo`

## Requirements
- R1: Out of reset, `phase_err` is 1 and `rd_data` carries the idle word (default 16'h0F0F).
- R2: While the read-domain error state is set, `rd_data` carries the idle word on every read cycle.
- R3: An `init_in` that is high for only one write cycle is not a request. This includes two one-cycle pulses with a low cycle between them. `phase_err` stays 1.
- R4: `init_in` seen high on two consecutive write edges is one request, and holding it longer does not make more than one. With the default two-stage synchronizers and equal clock rates, `phase_err` falls between 2 and 8 write cycles after the second high edge.
- R5: A re-centre places the read pointer so that the estimated separation equals DEPTH/2. The estimate is the synchronized write pointer minus the read pointer, plus the synchronizer depth. With equal clock rates `phase_err` then stays 0.
- R6: Words written while `phase_err` is 0 come out on `rd_data` in write order and unchanged, with none lost and none repeated.
- R7: When the estimated separation is at most GUARD (default 1) or at least DEPTH-GUARD (default 7), the error state is set on the next read cycle and `phase_err` rises. A slow writer and a fast writer both trigger this.
- R8: Once set, the error state stays set, even after the clocks fall back into step, until a valid init completes a re-centre.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock returned by the word source |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| wr_data | input | 16 | Transmit word, taken on every write edge |
| init_in | input | 1 | Re-centre request, must be high for two write cycles |
| phase_err | output | 1 | Pointer-collision flag, write domain, registered |
| rclk | input | 1 | Internal read clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| rd_data | output | 16 | Read word, or the idle word while in error |

## Verification
The bench stretches and shrinks the write period so the pointers drift both ways. A design with a one-sided collision test would never raise the flag for one of the two drift directions. After the clocks are brought back into step, it checks that the flag stays high. A design that compared only the live separation would clear the flag on its own, without any init. It sends single-cycle and split init pulses that a design qualifying on one high sample would wrongly accept. It also sends a long held pulse, and measures the flag's fall latency. A scoreboard tracks every real word across each re-centre. Any off-by-one in the re-centre target, or a misaligned idle mask, would show up as a dropped, repeated or corrupted word.

// File: rtl/txa_pkg.sv
`timescale 1ns/1ps
package txa_pkg;
  // Gray conversions on a 32-bit carrier; callers zero-extend and slice.
  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/txa_sync.sv
`timescale 1ns/1ps
module txa_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/txa_mem.sv
`timescale 1ns/1ps
module txa_mem #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) mem[waddr] <= wdata;
  always_ff @(posedge rclk) rdata <= mem[raddr];
endmodule

// File: rtl/txa_wr_ctrl.sv
`timescale 1ns/1ps
module txa_wr_ctrl #(
  parameter int AW = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          init_in,
  input  logic          rd_err,
  output logic [AW-1:0] wr_addr,
  output logic [AW:0]   wr_gray,
  output logic          req_tog,
  output logic          phase_err
);
  localparam int PW = AW + 1;
  localparam int WIN_MIN = 2;
  localparam int WIN_MAX = 2 * SYNC_STAGES + 4;

  logic [PW-1:0] wbin;
  logic init_q, fired, req_fire;

  // One request per high pulse, and only from the second high edge.
  assign req_fire = init_in && init_q && !fired;

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin    <= '0;
      wr_gray <= '0;
      init_q  <= 1'b0;
      fired   <= 1'b0;
      req_tog <= 1'b0;
    end else begin
      wbin    <= wbin + 1'b1;
      wr_gray <= PW'(txa_pkg::bin_to_gray(32'(wbin + 1'b1)));
      init_q  <= init_in;
      if (req_fire) begin
        req_tog <= ~req_tog;
        fired   <= 1'b1;
      end else if (!init_in) begin
        fired   <= 1'b0;
      end
    end
  end

  assign wr_addr = wbin[AW-1:0];

  txa_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_err_sync (
    .clk(wclk), .rst(wrst), .d(rd_err), .q(phase_err)
  );

  // Checker: cycles since the last accepted request, saturating.
  logic [4:0] since_req;
  always_ff @(posedge wclk) begin
    if (wrst) since_req <= 5'd31;
    else if (req_fire) since_req <= 5'd0;
    else if (since_req != 5'd31) since_req <= since_req + 5'd1;
  end

  assert_clear_window_R4: assert property (@(posedge wclk) disable iff (wrst)
    $fell(phase_err) |-> (since_req >= 5'(WIN_MIN) && since_req <= 5'(WIN_MAX)));
endmodule

// File: rtl/txa_rd_ctrl.sv
`timescale 1ns/1ps
module txa_rd_ctrl #(
  parameter int DW = 16,
  parameter int AW = 3,
  parameter int SYNC_STAGES = 2,
  parameter int GUARD = 1,
  parameter logic [DW-1:0] IDLE_WORD = 16'h0F0F
) (
  input  logic          rclk,
  input  logic          rrst,
  input  logic [AW:0]   wgray_s,
  input  logic          req_s,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] rd_addr,
  output logic          rd_err,
  output logic [DW-1:0] rd_data
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] LAG  = PW'(SYNC_STAGES);
  localparam logic [PW-1:0] HALF = PW'(DEPTH / 2);
  localparam logic [PW-1:0] LO   = PW'(GUARD);
  localparam logic [PW-1:0] HI   = PW'(DEPTH - GUARD);

  logic [PW-1:0] rbin, wsync_bin, sep;
  logic req_prev, err_d, recentre, near;

  always_comb begin
    wsync_bin = PW'(txa_pkg::gray_to_bin(32'(wgray_s)));
    sep       = wsync_bin - rbin + LAG;
    near      = (sep <= LO) || (sep >= HI);
    recentre  = req_s ^ req_prev;
  end

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin     <= '0;
      rd_err   <= 1'b1;
      req_prev <= 1'b0;
      err_d    <= 1'b1;
    end else begin
      req_prev <= req_s;
      err_d    <= rd_err;
      if (recentre) begin
        // +1 accounts for the write pointer advancing over this same cycle.
        rbin   <= wsync_bin + LAG - HALF + 1'b1;
        rd_err <= 1'b0;
      end else begin
        rbin <= rbin + 1'b1;
        if (near) rd_err <= 1'b1;
      end
    end
  end

  assign rd_addr = rbin[AW-1:0];
  assign rd_data = err_d ? IDLE_WORD : mem_q;

  assert_idle_on_err_R2: assert property (@(posedge rclk) disable iff (rrst)
    rd_err |=> (rd_data == IDLE_WORD));
  assert_centred_R5: assert property (@(posedge rclk) disable iff (rrst)
    recentre |=> (sep >= HALF - 1'b1 && sep <= HALF + 1'b1));
  assert_raise_on_near_R7: assert property (@(posedge rclk) disable iff (rrst)
    (near && !recentre) |=> rd_err);
  assert_err_sticky_R8: assert property (@(posedge rclk) disable iff (rrst)
    (rd_err && !recentre) |=> rd_err);
endmodule

// File: rtl/txalign_fifo.sv
`timescale 1ns/1ps
module txalign_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH = 8,
  parameter int SYNC_STAGES = 2,
  parameter int GUARD = 1,
  parameter logic [DATA_W-1:0] IDLE_WORD = 16'h0F0F
) (
  input  logic              wclk,
  input  logic              wrst,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              init_in,
  output logic              phase_err,
  input  logic              rclk,
  input  logic              rrst,
  output logic [DATA_W-1:0] rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [AW-1:0]     wr_addr, rd_addr;
  logic [PW-1:0]     wr_gray, wgray_s;
  logic              req_tog, req_s, rd_err;
  logic [DATA_W-1:0] mem_q;

  txa_wr_ctrl #(.AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_wr (
    .wclk(wclk), .wrst(wrst), .init_in(init_in), .rd_err(rd_err),
    .wr_addr(wr_addr), .wr_gray(wr_gray), .req_tog(req_tog), .phase_err(phase_err)
  );

  txa_mem #(.DW(DATA_W), .AW(AW)) u_mem (
    .wclk(wclk), .waddr(wr_addr), .wdata(wr_data),
    .rclk(rclk), .raddr(rd_addr), .rdata(mem_q)
  );

  txa_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ptr_sync (
    .clk(rclk), .rst(rrst), .d(wr_gray), .q(wgray_s)
  );

  txa_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
    .clk(rclk), .rst(rrst), .d(req_tog), .q(req_s)
  );

  txa_rd_ctrl #(.DW(DATA_W), .AW(AW), .SYNC_STAGES(SYNC_STAGES), .GUARD(GUARD),
                .IDLE_WORD(IDLE_WORD)) u_rd (
    .rclk(rclk), .rrst(rrst), .wgray_s(wgray_s), .req_s(req_s), .mem_q(mem_q),
    .rd_addr(rd_addr), .rd_err(rd_err), .rd_data(rd_data)
  );
endmodule

// File: tb/test_txalign_fifo.sv
`timescale 1ns/1ps
module test_txalign_fifo;
  localparam logic [15:0] IDLE  = 16'h0F0F;
  localparam logic [15:0] DUMMY = 16'hDDDD;
  localparam logic [15:0] BASE  = 16'h1000;

  logic wclk = 0, rclk = 0, wrst = 1, rrst = 1, init_in = 0;
  logic [15:0] wr_data = DUMMY;
  logic phase_err;
  logic [15:0] rd_data;
  realtime w_half = 4.0;

  int n_checks = 0, n_fail = 0, seq = 0, matched = 0;
  bit quiet = 1;
  logic [15:0] sb_q[$];

  txalign_fifo i_txalign_fifo (
    .wclk(wclk), .wrst(wrst), .wr_data(wr_data), .init_in(init_in),
    .phase_err(phase_err), .rclk(rclk), .rrst(rrst), .rd_data(rd_data)
  );

  initial forever #(w_half) wclk = ~wclk;
  initial begin #1; forever #4 rclk = ~rclk; end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: real words only while the flag is low and not quiet.
  initial forever begin
    @(negedge wclk);
    if (!wrst && !quiet && !phase_err) begin
      wr_data = BASE + 16'(seq);
      sb_q.push_back(wr_data);
      seq++;
    end else begin
      wr_data = DUMMY;
    end
  end

  // Monitor: every real word must match the head of the queue (R6).
  initial forever begin
    @(negedge rclk);
    if (!rrst && rd_data != IDLE && rd_data != DUMMY) begin
      if (sb_q.size() == 0) check(0, "R6 unexpected word", int'(rd_data), 0);
      else begin
        logic [15:0] exp_w;
        exp_w = sb_q.pop_front();
        check(rd_data == exp_w, "R6 word order", int'(rd_data), int'(exp_w));
        matched++;
      end
    end
  end

  task automatic do_init(input int hold, output int lat);
    @(negedge wclk); init_in = 1;
    repeat (2) @(negedge wclk);
    if (hold <= 2) init_in = 0;
    lat = 0;
    for (int k = 0; k < 30; k++) begin
      if (!phase_err) break;
      if (k + 2 >= hold) init_in = 0;
      @(negedge wclk);
      lat++;
    end
    init_in = 0;
  endtask

  task automatic wait_flag(input string tag);
    int n;
    n = 0;
    while (!phase_err && n < 600) begin @(negedge wclk); n++; end
    check(phase_err == 1, tag, int'(phase_err), 1);
  endtask

  task automatic stream(input int cycles, input string tag);
    int m0;
    m0 = matched;
    quiet = 0;
    for (int i = 0; i < cycles / 50; i++) begin
      repeat (50) @(negedge rclk);
      check(phase_err == 0, {tag, " R5 flag stays low"}, int'(phase_err), 0);
    end
    quiet = 1;
    repeat (30) @(negedge rclk);
    check(matched - m0 >= cycles - 20, {tag, " R6 words delivered"}, matched - m0, cycles - 20);
    check(sb_q.size() == 0, {tag, " R6 queue drained"}, sb_q.size(), 0);
  endtask

  initial begin
    int lat;
    repeat (10) @(posedge rclk);
    @(negedge wclk); wrst = 0; rrst = 0;
    @(negedge wclk);
    check(phase_err == 1, "R1 flag after reset", int'(phase_err), 1);
    @(negedge rclk);
    check(rd_data == IDLE, "R1 idle after reset", int'(rd_data), int'(IDLE));

    // R3: single and split pulses are ignored.
    @(negedge wclk); init_in = 1; @(negedge wclk); init_in = 0;
    repeat (20) @(negedge wclk);
    check(phase_err == 1, "R3 one-cycle pulse", int'(phase_err), 1);
    init_in = 1; @(negedge wclk); init_in = 0; @(negedge wclk);
    init_in = 1; @(negedge wclk); init_in = 0;
    repeat (20) @(negedge wclk);
    check(phase_err == 1, "R3 split pulses", int'(phase_err), 1);
    @(negedge rclk);
    check(rd_data == IDLE, "R2 idle while in error", int'(rd_data), int'(IDLE));

    // R4: two-cycle init.
    do_init(2, lat);
    check(lat >= 2 && lat <= 8, "R4 clear latency", lat, 4);
    stream(300, "steady");

    // R7: slow writer -> underflow side.
    w_half = 4.25;
    wait_flag("R7 slow writer raises flag");
    w_half = 4.0;
    repeat (100) @(negedge wclk);
    check(phase_err == 1, "R8 flag sticky after realign", int'(phase_err), 1);
    @(negedge rclk);
    check(rd_data == IDLE, "R2 idle while sticky", int'(rd_data), int'(IDLE));

    // R4: long hold counts as one request.
    do_init(12, lat);
    check(lat >= 2 && lat <= 8, "R4 long hold latency", lat, 4);
    stream(200, "after slow");

    // R7: fast writer -> overflow side.
    w_half = 3.75;
    wait_flag("R7 fast writer raises flag");
    w_half = 4.0;
    repeat (60) @(negedge wclk);
    check(phase_err == 1, "R8 flag sticky after fast drift", int'(phase_err), 1);
    do_init(2, lat);
    check(lat >= 2 && lat <= 8, "R4 clear latency after fast", lat, 4);
    stream(150, "after fast");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge rclk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule